// File: doc/BRIEF.md
# Interval Timer with Compare Interrupt

This block is a register-mapped interval timer. A prescaler turns the input clock into counting ticks, an up-counter advances once per tick, and a compare register sets an interrupt status flag when the count reaches the programmed value. Software sets up the divide select, the compare value and the interval-mode bits, then starts the counter through the control register. The flag stays set until software acknowledges it. The interrupt line is the flag gated by an enable bit.

With clear-on-match set, the counter returns to zero on every match, so the interrupt recurs with a fixed period. With clear-on-match off, the counter runs past the compare value and wraps at its full width. A counter-reset-enable bit lets a stop command also zero the count, but only once the counter has been started with that bit set. The live count can be read at any time.

Top module: `interval_timer`

## Requirements
- R1: After reset every register reads zero, `irq` is low, the counter is stopped at zero and the prescaler phase is zero.
- R2: With divider-enable (control bit 2) set, the counter advances once every `2 << sel` clocks, where `sel` is the divide-select register at 0x08. With divider-enable clear, it advances every clock. Starting from zero, the first match comes `div*(cmp+1)` clocks after the enabling write.
- R3: A tick on which the counter equals the compare register (0x10) sets the status flag, which is bit 0 of 0x04.
- R4: With clear-on-match (bit 1 of 0x0C) set, a match returns the counter to zero, so the next count read after the match is 0.
- R5: With clear-on-match clear, the counter continues past the compare value and wraps at 2^CNT_W. A later match after the wrap sets the flag again.
- R6: `irq` equals the status flag ANDed with interrupt-enable (bit 0 of 0x0C). The flag is set by a match even when the enable is off.
- R7: Writing 0x04 with bit 0 zero clears the flag. Writing it with bit 0 one leaves the flag unchanged.
- R8: A match in the same cycle as a clearing write leaves the flag set.
- R9: Counter-reset-enable (control bit 1) has no effect until the counter has been enabled (control bit 0) while bit 1 is set. After that, whenever bit 0 is clear and bit 1 is set, the counter is held at zero.
- R10: Offset 0x14 returns the live counter value. Offsets with no register read zero. The control register at 0x00 reads back as written in its low 5 bits.
- R11: The mode field is control bits 4:3. Only value 00 (interval) lets the counter run. Any other value holds it.
- R12: While the counter is stopped and no reset-enable clear applies, it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a clearing write that lands on the very cycle of a match, because match cycles normally come once per period. The bench sets the compare value to zero, turns on clear-on-match and turns off the divider. The counter then matches on every clock, so any acknowledge write coincides with a match. Reaching the wrap without clear-on-match needs a full pass of the counter, so the bench lets the undivided counter run through all 2^CNT_W states.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_DIV   = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_IMODE = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_CMP   = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_CNT   = 5'h14;

    typedef enum logic [1:0] {
        MODE_INTERVAL = 2'b00,
        MODE_RSV_A    = 2'b01,
        MODE_RSV_B    = 2'b10,
        MODE_RSV_C    = 2'b11
    } tmode_e;

    // bit0 run, bit1 reset-enable, bit2 divider-enable, bits 4:3 mode
    typedef struct packed {
        tmode_e mode;
        logic   div_en;
        logic   rst_en;
        logic   cnt_en;
    } ctrl_t;

    // bit0 interrupt enable, bit1 clear counter on match
    typedef struct packed {
        logic clr_on_match;
        logic irq_en;
    } imode_t;

    localparam int CTRL_W  = $bits(ctrl_t);
    localparam int IMODE_W = $bits(imode_t);

    // Terminal prescaler phase for divide-by-(2<<sel); zero when undivided.
    function automatic logic [31:0] pre_last(input logic div_en, input logic [31:0] sel);
        logic [31:0] d;
        d = 32'd2 << sel;
        return div_en ? (d - 32'd1) : 32'd0;
    endfunction
endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler
    import itmr_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             div_en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = 1 << SEL_W;

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] last;
    logic [31:0]      last_full;

    always_comb begin
        last_full = pre_last(div_en, 32'(sel));
        last      = last_full[PRE_W-1:0];
        tick      = run && (phase_q == last);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cnt_en,
    input  logic             rst_en,
    input  logic             clr_on_match,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             match,
    output logic             armed
);
    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    logic             force_zero;

    always_comb begin
        match      = tick && (cnt_q == cmp);
        force_zero = armed_q && rst_en && !cnt_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            if (!rst_en)     armed_q <= 1'b0;
            else if (cnt_en) armed_q <= 1'b1;

            if (force_zero)                 cnt_q <= '0;
            else if (match && clr_on_match) cnt_q <= '0;
            else if (tick)                  cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt   = cnt_q;
    assign armed = armed_q;
endmodule

// File: rtl/itmr_regs.sv
module itmr_regs
    import itmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              match,
    input  logic [CNT_W-1:0]  cnt,
    output ctrl_t             ctrl,
    output imode_t            imode,
    output logic [SEL_W-1:0]  sel,
    output logic [CNT_W-1:0]  cmp,
    output logic              flag,
    output logic [DATA_W-1:0] rdata
);
    ctrl_t            ctrl_q;
    imode_t           imode_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cmp_q;
    logic             flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            imode_q <= '0;
            sel_q   <= '0;
            cmp_q   <= '0;
            flag_q  <= 1'b0;
        end else begin
            if (we) begin
                case (addr)
                    OFF_CTRL:  ctrl_q  <= ctrl_t'(wdata[CTRL_W-1:0]);
                    OFF_DIV:   sel_q   <= wdata[SEL_W-1:0];
                    OFF_IMODE: imode_q <= imode_t'(wdata[IMODE_W-1:0]);
                    OFF_CMP:   cmp_q   <= wdata[CNT_W-1:0];
                    default:   ;
                endcase
            end
            // A match outranks an acknowledge in the same cycle.
            if (match) begin
                flag_q <= 1'b1;
            end else if (we && addr == OFF_STAT && !wdata[0]) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFF_CTRL:  rdata[CTRL_W-1:0]  = ctrl_q;
            OFF_STAT:  rdata[0]           = flag_q;
            OFF_DIV:   rdata[SEL_W-1:0]   = sel_q;
            OFF_IMODE: rdata[IMODE_W-1:0] = imode_q;
            OFF_CMP:   rdata[CNT_W-1:0]   = cmp_q;
            OFF_CNT:   rdata[CNT_W-1:0]   = cnt;
            default:   rdata = '0;
        endcase
    end

    assign ctrl  = ctrl_q;
    assign imode = imode_q;
    assign sel   = sel_q;
    assign cmp   = cmp_q;
    assign flag  = flag_q;
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    ctrl_t            ctrl;
    imode_t           imode;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] cmp;
    logic [CNT_W-1:0] cnt;
    logic             flag;
    logic             match;
    logic             tick;
    logic             armed;
    logic             run;

    assign run = ctrl.cnt_en && (ctrl.mode == MODE_INTERVAL);

    itmr_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .match (match),
        .cnt   (cnt),
        .ctrl  (ctrl),
        .imode (imode),
        .sel   (sel),
        .cmp   (cmp),
        .flag  (flag),
        .rdata (bus_rdata)
    );

    itmr_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .div_en (ctrl.div_en),
        .sel    (sel),
        .tick   (tick)
    );

    itmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .cnt_en       (ctrl.cnt_en),
        .rst_en       (ctrl.rst_en),
        .clr_on_match (imode.clr_on_match),
        .cmp          (cmp),
        .cnt          (cnt),
        .match        (match),
        .armed        (armed)
    );

    assign irq = flag && imode.irq_en;
endmodule

// File: rtl/itmr_checker.sv
module itmr_checker
    import itmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              cnt_en,
    input logic              rst_en,
    input logic              armed,
    input logic              tick,
    input logic              match,
    input logic              clr_on_match,
    input logic [CNT_W-1:0]  cnt,
    input logic              flag,
    input logic              irq
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (cnt == '0 && !flag && !irq));

    a_r2_tick_steps: assert property (@(posedge clk) disable iff (rst)
        (tick && !match) |=> (cnt == $past(cnt) + 1'b1));

    a_r3_match_sets_flag: assert property (@(posedge clk) disable iff (rst)
        match |=> flag);

    a_r4_clear_on_match: assert property (@(posedge clk) disable iff (rst)
        (match && clr_on_match) |=> (cnt == '0));

    a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag);

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !(we && addr == OFF_STAT && !wdata[0])) |=> flag);

    a_r9_forced_zero: assert property (@(posedge clk) disable iff (rst)
        (armed && rst_en && !cnt_en) |=> (cnt == '0));

    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !(armed && rst_en && !cnt_en)) |=> $stable(cnt));
endmodule

bind interval_timer itmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .we           (bus_we),
    .addr         (bus_addr),
    .wdata        (bus_wdata),
    .cnt_en       (ctrl.cnt_en),
    .rst_en       (ctrl.rst_en),
    .armed        (armed),
    .tick         (tick),
    .match        (match),
    .clr_on_match (imode.clr_on_match),
    .cnt          (cnt),
    .flag         (flag),
    .irq          (irq)
);

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    interval_timer #(.CNT_W(16), .SEL_W(3)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct packed {
        logic        div_en;
        logic [2:0]  sel;
        logic [15:0] cmp;
        logic        clr;
        logic [31:0] n_exp;
        logic [15:0] cnt_exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 3'd0, 16'd15, 1'b1, 32'd16,   16'd0},
        '{1'b1, 3'd0, 16'd15, 1'b1, 32'd32,   16'd0},
        '{1'b1, 3'd1, 16'd15, 1'b1, 32'd64,   16'd0},
        '{1'b1, 3'd3, 16'd15, 1'b1, 32'd256,  16'd0},
        '{1'b1, 3'd2, 16'd20, 1'b0, 32'd168,  16'd21},
        '{1'b1, 3'd7, 16'd15, 1'b1, 32'd4096, 16'd0}
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(input int limit, output int n);
        n = 0;
        while (n < limit) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (irq) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] v1;
        int n;

        // R1: reset state
        do_reset();
        @(negedge clk);
        for (int a = 0; a < 6; a++) begin
            peek(5'(a * 4), d);
            check(d == 0, "R1 reg zero after reset", d, 0);
        end
        check(irq == 1'b0, "R1 irq low after reset", irq, 0);

        // R2 R3 R4: table of prescale and compare settings
        for (int i = 0; i < 6; i++) begin
            do_reset();
            wr(5'h08, 32'(VECS[i].sel));
            wr(5'h0C, {30'd0, VECS[i].clr, 1'b1});
            wr(5'h10, 32'(VECS[i].cmp));
            wr(5'h00, {29'd0, VECS[i].div_en, 2'b01});
            wait_irq(5000, n);
            check(n == int'(VECS[i].n_exp), "R2 R3 clocks to first match", n, VECS[i].n_exp);
            peek(5'h14, d);
            check(d == 32'(VECS[i].cnt_exp), "R4 R5 count right after match", d, VECS[i].cnt_exp);
        end

        // R5 R7: wrap without clear-on-match, write-one and write-zero to status
        do_reset();
        wr(5'h0C, 32'h1);
        wr(5'h10, 32'd3);
        wr(5'h00, 32'h1);
        wait_irq(100, n);
        check(n == 4, "R5 first match", n, 4);
        wr(5'h04, 32'h1);
        check(irq == 1'b1, "R7 write one keeps flag", irq, 1);
        wr(5'h04, 32'h0);
        check(irq == 1'b0, "R7 write zero clears flag", irq, 0);
        wait_irq(70000, n);
        check(irq == 1'b1, "R5 match again after wrap", irq, 1);
        peek(5'h14, d);
        check(d == 32'd4, "R5 count after wrap match", d, 4);

        // R6: flag without enable
        do_reset();
        wr(5'h10, 32'd15);
        wr(5'h00, 32'h1);
        cyc(25);
        check(irq == 1'b0, "R6 irq masked", irq, 0);
        peek(5'h04, d);
        check(d == 32'h1, "R6 flag set while masked", d, 1);
        wr(5'h0C, 32'h1);
        check(irq == 1'b1, "R6 irq after enable", irq, 1);

        // R8: acknowledge coinciding with a match
        do_reset();
        wr(5'h0C, 32'h3);
        wr(5'h10, 32'd0);
        wr(5'h00, 32'h1);
        cyc(3);
        wr(5'h04, 32'h0);
        peek(5'h04, d);
        check(d == 32'h1, "R8 match beats clear", d, 1);
        wr(5'h00, 32'h0);
        wr(5'h04, 32'h0);
        peek(5'h04, d);
        check(d == 32'h0, "R7 clear once stopped", d, 0);
        check(irq == 1'b0, "R7 irq low once cleared", irq, 0);

        // R9 R12: reset-enable arming
        do_reset();
        wr(5'h10, 32'hFFFF);
        wr(5'h00, 32'h1);
        cyc(10);
        wr(5'h00, 32'h2);
        cyc(2);
        peek(5'h14, v1);
        check(v1 != 0, "R9 unarmed stop keeps count", v1, 1);
        cyc(3);
        peek(5'h14, d);
        check(d == v1, "R12 stopped count holds", d, v1);
        wr(5'h00, 32'h3);
        cyc(5);
        peek(5'h14, d);
        check(d > v1, "R9 count resumes", d, v1 + 1);
        wr(5'h00, 32'h2);
        cyc(2);
        peek(5'h14, d);
        check(d == 0, "R9 armed stop zeroes count", d, 0);

        // R11: non-interval mode holds counter
        do_reset();
        wr(5'h00, 32'h9);
        cyc(10);
        peek(5'h14, d);
        check(d == 0, "R11 other mode holds", d, 0);
        wr(5'h00, 32'h1);
        cyc(5);
        peek(5'h14, d);
        check(d != 0, "R11 interval mode counts", d, 1);

        // R10: unmapped reads and control read-back
        peek(5'h18, d);
        check(d == 0, "R10 unmapped 0x18", d, 0);
        peek(5'h1C, d);
        check(d == 0, "R10 unmapped 0x1C", d, 0);
        wr(5'h00, 32'h1E);
        peek(5'h00, d);
        check(d == 32'h1E, "R10 control read-back", d, 32'h1E);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule